// File: doc/BRIEF.md
# Segment Address Translation Unit

This block maps a 14-bit virtual address onto a 16-bit physical address through a four-entry segment table. The upper two address bits pick a table entry, and the lower twelve bits are an offset into that segment. Each entry holds a physical base, a length, a valid flag and a read-only flag. When the access is legal, the result is the base plus the offset. When it is not legal, the block returns a fault code and the physical address is zero.

Software loads the table one entry at a time through a write port. An operating system reloads all four entries when it switches from one process to another. Translation requests enter on a request port and the result comes back one clock later with a strobe. A write to a read-only segment returns its own fault kind, so that a kernel can catch the write and copy the segment before it grants write access.

Top module: `seg_xlate`

## Requirements
- R1: Bits 13:12 of `req_vaddr` select the table entry, and bits 11:0 are the offset.
- R2: When `tbl_we` is high, entry `tbl_idx` is loaded with base, length, valid and read-only. The new value is used by requests from the next cycle onward. A request in the same cycle as the write sees the old entry. All other entries keep their values.
- R3: A legal access returns fault code 0 and a physical address equal to the base plus the zero-extended offset, truncated to 16 bits.
- R4: An offset at or above the entry length returns fault code 1 (bounds) with a physical address of 0.
- R5: An access to an entry whose valid flag is clear returns fault code 2 (invalid) with a physical address of 0. This applies for any offset and for reads and writes alike, and this fault wins over bounds.
- R6: A write (`req_write`=1) to a read-only entry with an in-range offset returns fault code 3 (protection) with a physical address of 0. A read of that entry is legal. A bounds fault wins over protection.
- R7: Every cycle with `req_valid` high produces `rsp_valid` high in the following cycle. A cycle without a request produces `rsp_valid`, `rsp_paddr` and `rsp_fault` all at 0 in the following cycle.
- R8: Reset clears every entry to invalid and drives all response outputs to 0.
- R9: An entry with a length of 0 faults every access with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table entry write enable |
| tbl_idx | input | 2 | Entry to write |
| tbl_base | input | 16 | Physical base of the segment |
| tbl_len | input | 13 | Segment length in bytes (0 to 0x1000) |
| tbl_valid | input | 1 | Entry valid flag |
| tbl_ronly | input | 1 | Entry read-only flag |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 invalid, 3 protection |

## Verification
A table write and a translation can happen in the same cycle, and both can target the same entry. The bench provokes this twice. The first time, it loads a valid entry while it requests the old invalid entry. The second time, it changes a segment's base while it requests that segment. In both cases the expected response is computed from the table as it was before the write, and the request in the next cycle is expected to use the new entry. The scoreboard also places fault kinds in competition: an invalid entry with an out-of-range offset, and a write to a read-only segment with an out-of-range offset. Each must resolve to the higher-priority code.

// File: rtl/segx_pkg.sv
package segx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUNDS  = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } seg_fault_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 2,
    parameter int PA_W  = 16,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEG_W-1:0] widx,
    input  logic [PA_W-1:0]  wbase,
    input  logic [LEN_W-1:0] wlen,
    input  logic             wvalid,
    input  logic             wronly,
    input  logic [SEG_W-1:0] ridx,
    output logic [PA_W-1:0]  rbase,
    output logic [LEN_W-1:0] rlen,
    output logic             rvalid,
    output logic             rronly
);
    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic             valid;
        logic             ronly;
        logic [LEN_W-1:0] len;
        logic [PA_W-1:0]  base;
    } ent_t;

    ent_t tab_d [NSEG];
    ent_t tab_q [NSEG];

    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            tab_d[i] = tab_q[i];
            if (we && widx == SEG_W'(i)) begin
                tab_d[i].valid = wvalid;
                tab_d[i].ronly = wronly;
                tab_d[i].len   = wlen;
                tab_d[i].base  = wbase;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) tab_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSEG; i++) tab_q[i] <= tab_d[i];
        end
    end

    assign rbase  = tab_q[ridx].base;
    assign rlen   = tab_q[ridx].len;
    assign rvalid = tab_q[ridx].valid;
    assign rronly = tab_q[ridx].ronly;

    for (genvar g = 0; g < NSEG; g++) begin : g_chk
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == SEG_W'(g)) |=> (tab_q[g].base == $past(wbase) &&
                                            tab_q[g].len == $past(wlen) &&
                                            tab_q[g].valid == $past(wvalid)));
        assert_entry_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && widx == SEG_W'(g)) |=> $stable(tab_q[g]));
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import segx_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int LEN_W = 13
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    input  logic [PA_W-1:0]  base,
    input  logic [LEN_W-1:0] len,
    input  logic             ent_valid,
    input  logic             ent_ronly,
    output logic [PA_W-1:0]  paddr,
    output seg_fault_e       fault
);
    logic out_of_range;

    always_comb begin
        out_of_range = LEN_W'(offset) >= len;
        paddr        = '0;
        if (!ent_valid)                fault = FLT_INVALID;
        else if (out_of_range)         fault = FLT_BOUNDS;
        else if (is_write && ent_ronly) fault = FLT_PROT;
        else begin
            fault = FLT_NONE;
            paddr = base + PA_W'(offset);
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import segx_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int SEG_W = 2,
    parameter int PA_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tbl_we,
    input  logic [SEG_W-1:0]         tbl_idx,
    input  logic [PA_W-1:0]          tbl_base,
    input  logic [VA_W-SEG_W:0]      tbl_len,
    input  logic                     tbl_valid,
    input  logic                     tbl_ronly,
    input  logic                     req_valid,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic                     req_write,
    output logic                     rsp_valid,
    output logic [PA_W-1:0]          rsp_paddr,
    output logic [1:0]               rsp_fault
);
    localparam int OFF_W = VA_W - SEG_W;
    localparam int LEN_W = OFF_W + 1;

    typedef struct packed {
        logic             valid;
        logic [PA_W-1:0]  paddr;
        seg_fault_e       fault;
    } rsp_t;

    logic [SEG_W-1:0] seg_sel;
    logic [OFF_W-1:0] seg_off;
    logic [PA_W-1:0]  ent_base;
    logic [LEN_W-1:0] ent_len;
    logic             ent_valid, ent_ronly;
    logic [PA_W-1:0]  xl_paddr;
    seg_fault_e       xl_fault;
    rsp_t             rsp_d, rsp_q;

    assign seg_sel = req_vaddr[VA_W-1:OFF_W];
    assign seg_off = req_vaddr[OFF_W-1:0];

    seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LEN_W(LEN_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .widx(tbl_idx), .wbase(tbl_base), .wlen(tbl_len),
        .wvalid(tbl_valid), .wronly(tbl_ronly),
        .ridx(seg_sel), .rbase(ent_base), .rlen(ent_len),
        .rvalid(ent_valid), .rronly(ent_ronly)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)) u_check (
        .offset(seg_off), .is_write(req_write),
        .base(ent_base), .len(ent_len),
        .ent_valid(ent_valid), .ent_ronly(ent_ronly),
        .paddr(xl_paddr), .fault(xl_fault)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.paddr = xl_paddr;
            rsp_d.fault = xl_fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;

    assert_rsp_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_fault == 2'd0 && rsp_paddr == '0));
    assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);
    assert_prot_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault == 2'd3) |-> $past(req_write));
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst_n;
    logic        tbl_we, tbl_valid, tbl_ronly;
    logic [1:0]  tbl_idx;
    logic [15:0] tbl_base;
    logic [12:0] tbl_len;
    logic        req_valid, req_write;
    logic [13:0] req_vaddr;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .tbl_valid(tbl_valid), .tbl_ronly(tbl_ronly),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        logic        v;
        logic [15:0] pa;
        logic [1:0]  f;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [15:0] m_base [4];
    logic [12:0] m_len  [4];
    logic        m_val  [4];
    logic        m_ro   [4];

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // one cycle: optional table write and optional request
    task automatic step(input logic we, input logic [1:0] wi, input logic [15:0] wb,
                        input logic [12:0] wl, input logic wv, input logic wr,
                        input logic rv, input logic [13:0] va, input logic wrq,
                        input string tag);
        exp_t e;
        logic [1:0]  s;
        logic [11:0] o;
        @(negedge clk);
        tbl_we = we; tbl_idx = wi; tbl_base = wb; tbl_len = wl;
        tbl_valid = wv; tbl_ronly = wr;
        req_valid = rv; req_vaddr = va; req_write = wrq;
        s = va[13:12]; o = va[11:0];
        e.v = rv; e.pa = '0; e.f = 2'd0; e.tag = tag;
        if (rv) begin
            if (!m_val[s])                       e.f = 2'd2;
            else if ({1'b0, o} >= m_len[s])      e.f = 2'd1;
            else if (wrq && m_ro[s])             e.f = 2'd3;
            else e.pa = m_base[s] + {4'd0, o};
        end
        sb.push_back(e);
        if (we) begin
            m_base[wi] = wb; m_len[wi] = wl; m_val[wi] = wv; m_ro[wi] = wr;
        end
    endtask

    task automatic load(input logic [1:0] wi, input logic [15:0] wb, input logic [12:0] wl,
                        input logic wv, input logic wr);
        step(1, wi, wb, wl, wv, wr, 0, 0, 0, "R2 load");
    endtask

    task automatic xl(input logic [13:0] va, input logic wrq, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, va, wrq, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compares each response against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_valid == e.v && rsp_paddr == e.pa && rsp_fault == e.f, e.tag,
                      $sformatf("v=%0b pa=%h f=%0d", rsp_valid, rsp_paddr, rsp_fault),
                      $sformatf("v=%0b pa=%h f=%0d", e.v, e.pa, e.f));
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            bad++;
            $display("FAIL R7 watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_len[i] = '0; m_val[i] = 0; m_ro[i] = 0;
        end
        rst_n = 0; tbl_we = 0; tbl_idx = 0; tbl_base = 0; tbl_len = 0;
        tbl_valid = 0; tbl_ronly = 0; req_valid = 0; req_vaddr = 0; req_write = 0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 0 && rsp_paddr == 0 && rsp_fault == 0, "R8 reset outputs",
              $sformatf("v=%0b pa=%h f=%0d", rsp_valid, rsp_paddr, rsp_fault), "all 0");
        rst_n = 1;

        // R8: every entry invalid after reset
        for (int s = 0; s < 4; s++) xl(14'(s << 12), 0, "R8 entry invalid after reset");

        // R2: same-cycle write and request see the old entry
        step(1, 0, 16'h4000, 13'h700, 1, 1, 1, 14'h0240, 0, "R2 same-cycle old entry");
        xl(14'h0240, 0, "R2 new entry next cycle / R3");
        load(1, 16'h0000, 13'h500, 1, 0);
        load(2, 16'h0000, 13'h000, 0, 0);
        load(3, 16'h2000, 13'h1000, 1, 0);

        // R1/R3: legal translations across segments, back to back
        xl(14'h1108, 0, "R1 R3 data segment");
        xl(14'h3000, 1, "R1 R3 stack low edge");
        xl(14'h3FFF, 0, "R3 stack last byte");
        xl(14'h06FF, 0, "R3 code last legal byte");

        // R4: bounds
        xl(14'h0700, 0, "R4 code at length");
        xl(14'h1500, 1, "R4 data at length");
        xl(14'h1FFF, 0, "R4 data far beyond");

        // R5: invalid beats bounds, any access kind
        xl(14'h2000, 0, "R5 invalid read");
        xl(14'h2FFF, 1, "R5 invalid write beyond length");

        // R6: protection
        xl(14'h0240, 1, "R6 write read-only");
        xl(14'h0244, 0, "R6 read read-only ok");
        xl(14'h0800, 1, "R6 bounds beats protection");

        // R7: idle gap then request
        idle("R7 idle cycle quiet");
        xl(14'h1000, 1, "R7 request after idle");

        // R9: zero length
        load(2, 16'h8000, 13'h000, 1, 0);
        xl(14'h2000, 0, "R9 zero length offset 0");

        // R3: wrap at 16 bits
        load(1, 16'hFF00, 13'h1000, 1, 0);
        xl(14'h1200, 0, "R3 address wraps");

        // R2: base change while requesting same entry, then context switch
        step(1, 3, 16'h9000, 13'h1000, 1, 0, 1, 14'h3010, 0, "R2 same-cycle base change");
        xl(14'h3010, 0, "R2 base change visible");
        load(0, 16'h1000, 13'h100, 1, 0);
        load(1, 16'h0000, 13'h000, 0, 0);
        xl(14'h00FF, 1, "R2 context switch seg0 writable");
        xl(14'h1000, 0, "R2 context switch seg1 invalid");
        xl(14'h2000, 0, "R2 untouched entry kept");

        idle("R7 drain");
        idle("R7 drain");
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule